// File: doc/BRIEF.md
# Synchronous Burst Memory Latency and Wait Controller

This block is the device-side sequencer of a synchronous burst pseudo-static memory port. On each rising clock it looks at chip select, the address strobe and the write strobe. When both selects are active and no burst is running, it captures the start address and counts out a programmed initial latency. It then runs a programmed number of data beats, with the word address going up by one per beat and wrapping at the end of the array.

A wait pin tells the host which clock periods carry a valid beat. It moves to its valid level one period ahead of every beat, and reads and writes use the same timing. A configuration input picks whether the valid level is high or low. Read data comes from an output register that is loaded one clock ahead of each beat. Its enable is asserted only while read beats are on the bus.

Raising chip select in the middle of a burst ends it on that edge. A host can use this to get one-beat or two-beat reads from a longer programmed length. A command seen while a burst is in progress is dropped. The storage is a small register file that resets to zero.

Top module: `sbm_burst_ctrl`

## Requirements
- R1: After reset, `wait_oe` and `dq_oe` are low and every array word reads back as zero.
- R2: A burst starts on a rising edge (edge 0) where `cs_n`=0 and `adv_n`=0 and no burst is in progress. `addr` is captured on that edge as the address of beat 0. `we_n`=0 selects a write burst and `we_n`=1 a read burst.
- R3: With latency L and length B, read beat k (0 ≤ k < B) is on `dq_out` during the clock period that follows edge L+k. It holds the word at address (start+k) modulo 2^ADDR_W.
- R4: In a write burst, the word on `dq_in` is written to address (start+k) modulo 2^ADDR_W at edge L+k+1.
- R5: The wait pin shows its valid level during the periods after edges L−1 through L+B−2, one period ahead of each beat. Reads and writes use the same timing. It shows the inactive level at all other times while `cs_n` is low.
- R6: With `cfg_wait_high`=1 the valid level of `wait_out` is 1 and the inactive level is 0. With `cfg_wait_high`=0 both levels are inverted.
- R7: `wait_oe` is high exactly while `cs_n` is low. `dq_oe` is high only during the read beat periods of R3.
- R8: If `cs_n` is high at a rising edge during a burst, the burst ends on that edge. `dq_oe` is low from the next period on, no later beats appear, and a new burst can start on the next edge with `cs_n` low.
- R9: A start condition at any edge from edge 1 through edge L+B of a running burst is ignored. The earliest new start is edge L+B+1.
- R10: Latency (2 to 2^LAT_W−1) and burst length (1 to 2^BLEN_W−1) are taken from `cfg_latency` and `cfg_burst_len`. Each burst follows the values that were present when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write strobe, low for a write burst |
| addr | input | ADDR_W | Start word address |
| dq_in | input | DATA_W | Write data from host |
| dq_out | output | DATA_W | Read data to host |
| dq_oe | output | 1 | Drive enable for the read data bus |
| wait_out | output | 1 | Beat-valid indication, polarity set by configuration |
| wait_oe | output | 1 | Drive enable for the wait pin |
| cfg_latency | input | LAT_W | Initial latency in clocks |
| cfg_burst_len | input | BLEN_W | Beats per burst |
| cfg_wait_high | input | 1 | 1: valid level is high; 0: valid level is low |

## Verification
The assertions assume that the three configuration inputs stay constant while a burst is running. They also assume latency is at least 2 and burst length at least 1, so that the beat counter's bound and the wait-before-data relation stay meaningful. The bench changes configuration only between bursts, after the controller has spent at least one idle period with the wait pin at its inactive level. It draws random latencies from 2 to 9 and lengths from 1 to 8, plus a directed burst at the largest values. Early stops are applied only to read bursts, and only before the last beat.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   // Control flags passed from the sequencer to the datapath and the pins
   typedef struct packed {
      logic busy;   // a burst is in progress
      logic is_wr;  // the burst in progress is a write
      logic win;    // this period is one before a beat (wait valid)
      logic beat;   // this period carries a beat
   } sbm_ctl_t;

   function automatic int sbm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sbm_seq.sv
module sbm_seq
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LAT_W  = 4,
   parameter int BLEN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LAT_W-1:0]  cfg_latency,
   input  logic [BLEN_W-1:0] cfg_burst_len,
   output sbm_ctl_t          ctl,
   output logic [ADDR_W-1:0] ptr
);
   localparam int TICK_W = sbm_max(LAT_W, BLEN_W) + 2;

   logic              busy_q, wr_q, beat_q;
   logic [TICK_W-1:0] tick_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [TICK_W-1:0] lat_x, len_x, win_lo, win_hi, end_tick;
   logic              start, last, win, ptr_step;

   always_comb begin
      lat_x    = TICK_W'(cfg_latency);
      len_x    = TICK_W'(cfg_burst_len);
      win_lo   = lat_x - TICK_W'(1);
      win_hi   = lat_x + len_x - TICK_W'(2);
      end_tick = lat_x + len_x - TICK_W'(1);
      start    = !busy_q && !cs_n && !adv_n;
      last     = busy_q && (tick_q == end_tick);
      win      = busy_q && (tick_q >= win_lo) && (tick_q <= win_hi)
                 && (len_x != '0);
      ptr_step = wr_q ? beat_q : win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         beat_q <= 1'b0;
         tick_q <= '0;
         ptr_q  <= '0;
      end else if (busy_q && cs_n) begin
         busy_q <= 1'b0;
         beat_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         wr_q   <= !we_n;
         beat_q <= 1'b0;
         tick_q <= '0;
         ptr_q  <= addr;
      end else if (busy_q) begin
         tick_q <= tick_q + TICK_W'(1);
         beat_q <= win;
         if (last) busy_q <= 1'b0;
         if (ptr_step) ptr_q <= ptr_q + ADDR_W'(1);
      end else begin
         beat_q <= 1'b0;
      end
   end

   assign ctl = '{busy: busy_q, is_wr: wr_q, win: win, beat: beat_q};
   assign ptr = ptr_q;

endmodule

// File: rtl/sbm_array.sv
module sbm_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_v [DEPTH];
   logic [DATA_W-1:0] rd_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (wr_en && (ptr == ADDR_W'(i)))     q <= wr_data;
      end
      assign word_v[i] = q;
   end

   // output register, loaded one clock ahead of each read beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= word_v[ptr];
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/sbm_pins.sv
module sbm_pins
   import sbm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cs_n,
   input  logic     cfg_wait_high,
   input  sbm_ctl_t ctl,
   output logic     wait_out,
   output logic     wait_oe,
   output logic     dq_oe
);
   logic oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= ctl.win && !ctl.is_wr && !cs_n;
   end

   assign wait_out = cfg_wait_high ? ctl.win : !ctl.win;
   assign wait_oe  = !cs_n;
   assign dq_oe    = oe_q;

endmodule

// File: rtl/sbm_burst_ctrl.sv
module sbm_burst_ctrl
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int LAT_W  = 4,
   parameter int BLEN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              wait_out,
   output logic              wait_oe,
   input  logic [LAT_W-1:0]  cfg_latency,
   input  logic [BLEN_W-1:0] cfg_burst_len,
   input  logic              cfg_wait_high
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("sbm_burst_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sbm_burst_ctrl: DATA_W must be positive");
   end
   if (LAT_W < 2 || BLEN_W < 1) begin : g_bad_cfg
      $error("sbm_burst_ctrl: configuration widths too small");
   end

   sbm_ctl_t          ctl;
   logic [ADDR_W-1:0] ptr;
   logic              wr_en, rd_en;

   sbm_seq #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .BLEN_W(BLEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
      .addr(addr), .cfg_latency(cfg_latency), .cfg_burst_len(cfg_burst_len),
      .ctl(ctl), .ptr(ptr)
   );

   assign wr_en = ctl.beat && ctl.is_wr && !cs_n;
   assign rd_en = ctl.win && !ctl.is_wr && !cs_n;

   sbm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ptr(ptr),
      .wr_data(dq_in), .rd_data(dq_out)
   );

   sbm_pins u_pins (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_wait_high(cfg_wait_high),
      .ctl(ctl), .wait_out(wait_out), .wait_oe(wait_oe), .dq_oe(dq_oe)
   );

endmodule

// File: rtl/sbm_burst_ctrl_chk.sv
module sbm_burst_ctrl_chk #(
   parameter int BLEN_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              dq_oe,
   input logic              wait_out,
   input logic              wait_oe,
   input logic [BLEN_W-1:0] cfg_burst_len,
   input logic              cfg_wait_high
);
   logic [BLEN_W:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         run_q <= '0;
      else if (!dq_oe)                    run_q <= '0;
      else if (run_q != {(BLEN_W+1){1'b1}}) run_q <= run_q + 1'b1;
   end

   // R5: a read data window opens only after a period with wait at valid level
   p_wait_leads_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(wait_oe && (wait_out == cfg_wait_high)));

   // R8: chip select high at an edge leaves the data bus undriven afterwards
   p_stop_releases_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !dq_oe);

   // R7: read data is driven only after an edge with chip select low
   p_oe_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!cs_n));

   // R3: no more consecutive read beats than the programmed length
   p_beats_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (run_q < {1'b0, cfg_burst_len}));

endmodule

bind sbm_burst_ctrl sbm_burst_ctrl_chk #(.BLEN_W(BLEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_oe(dq_oe),
   .wait_out(wait_out), .wait_oe(wait_oe),
   .cfg_burst_len(cfg_burst_len), .cfg_wait_high(cfg_wait_high)
);

// File: tb/sbm_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbm_burst_ctrl_tb_top;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cs_n, adv_n, we_n;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] dq_in, dq_out;
   logic              dq_oe, wait_out, wait_oe;
   logic [3:0]        cfg_latency, cfg_burst_len;
   logic              cfg_wait_high;

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   logic [DATA_W-1:0] ref_mem [DEPTH];

   always #4 clk = ~clk;

   sbm_burst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(4), .BLEN_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .wait_out(wait_out), .wait_oe(wait_oe), .cfg_latency(cfg_latency),
      .cfg_burst_len(cfg_burst_len), .cfg_wait_high(cfg_wait_high)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected wait level in period n of a burst
   function automatic bit exp_wait(input int n, input int lat, input int len, input bit pol);
      bit valid = (n >= lat - 1) && (n <= lat + len - 2);
      return valid ? pol : !pol;
   endfunction

   function automatic bit exp_oe(input int n, input int lat, input int len, input bit wr);
      return !wr && (n >= lat) && (n <= lat + len - 1);
   endfunction

   task automatic idle_checks(input int cycles, input string req);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk({req, " wait idle"}, int'(wait_out), int'(!cfg_wait_high));
         chk({req, " oe idle"}, int'(dq_oe), 0);
      end
   endtask

   // one burst; called at a negedge, returns at a negedge
   task automatic burst(input bit wr, input int a, input int stop, input bit poke,
                        input string lbl);
      int lat = int'(cfg_latency);
      int len = int'(cfg_burst_len);
      bit done = 0;
      cs_n = 1'b0; adv_n = 1'b0; we_n = !wr; addr = ADDR_W'(a);
      for (int n = 0; n <= lat + len && !done; n++) begin
         @(negedge clk);
         adv_n = 1'b1;
         if (stop > 0 && n == lat + stop) begin
            chk("R8 stop oe", int'(dq_oe), 0);
            chk("R7 wait hiz", int'(wait_oe), 0);
            done = 1;
         end else if (n == lat + len) begin
            chk("R5 wait end", int'(wait_out), int'(!cfg_wait_high));
            chk("R7 oe end", int'(dq_oe), 0);
            done = 1;
         end else begin
            chk("R7 wait_oe", int'(wait_oe), 1);
            chk("R5 wait", int'(wait_out), int'(exp_wait(n, lat, len, cfg_wait_high)));
            chk("R7 dq_oe", int'(dq_oe), int'(exp_oe(n, lat, len, wr)));
            if (exp_oe(n, lat, len, wr))
               chk((n == lat) ? "R2 first beat" : lbl, int'(dq_out),
                   int'(ref_mem[(a + n - lat) % DEPTH]));
            if (wr && n >= lat) begin
               dq_in = DATA_W'($urandom);
               ref_mem[(a + n - lat) % DEPTH] = dq_in;
            end
            if (poke && n == 1) begin
               adv_n = 1'b0; addr = ADDR_W'(a ^ 5); we_n = wr;
            end
            if (poke && n == lat + len - 1) adv_n = 1'b0;
            if (stop > 0 && n == lat + stop - 1) cs_n = 1'b1;
         end
      end
      cs_n = 1'b0; adv_n = 1'b1; we_n = 1'b1;
      idle_checks(poke ? lat + 2 : 1, poke ? "R9" : (stop > 0 ? "R8" : "R5"));
   endtask

   task automatic set_cfg(input int lat, input int len, input bit pol);
      cfg_latency = 4'(lat); cfg_burst_len = 4'(len); cfg_wait_high = pol;
      idle_checks(1, "R6");
   endtask

   initial begin
      #1600000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      rst_n = 1'b0; cs_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; addr = '0; dq_in = '0;
      cfg_latency = 4'd5; cfg_burst_len = 4'd4; cfg_wait_high = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 wait_oe reset", int'(wait_oe), 0);
      chk("R1 dq_oe reset", int'(dq_oe), 0);
      cs_n = 1'b0;
      idle_checks(1, "R6 low-enable");

      burst(1'b0, 0, 0, 1'b0, "R1 zero read");
      burst(1'b1, 10, 0, 1'b0, "R4");
      burst(1'b0, 10, 0, 1'b0, "R4 readback");
      burst(1'b1, 62, 0, 1'b0, "R4");
      burst(1'b0, 62, 0, 1'b0, "R3 wrap");

      set_cfg(2, 1, 1'b1);
      burst(1'b1, 20, 0, 1'b0, "R6");
      burst(1'b0, 20, 0, 1'b0, "R6 high-enable");

      set_cfg(5, 4, 1'b0);
      burst(1'b0, 10, 1, 1'b0, "R8 one beat");
      burst(1'b0, 10, 2, 1'b0, "R8 two beats");
      burst(1'b0, 10, 0, 1'b0, "R8 after stop");
      burst(1'b0, 10, 0, 1'b1, "R9 ignored cmd");

      set_cfg(15, 15, 1'b1);
      burst(1'b1, 40, 0, 1'b0, "R10");
      burst(1'b0, 40, 0, 1'b0, "R10 max cfg");

      for (int r = 0; r < 40; r++) begin
         int lat = 2 + int'($urandom % 8);
         int len = 1 + int'($urandom % 8);
         bit wr  = 1'($urandom);
         int a   = int'($urandom % DEPTH);
         int stp = (!wr && len > 1 && ($urandom % 3 == 0)) ? 1 + int'($urandom % (len - 1)) : 0;
         set_cfg(lat, len, 1'($urandom));
         burst(wr, a, stp, 1'b0, "R10 random");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule